// File: doc/BRIEF.md
# Configurable Asynchronous Frame Receiver

This block recovers characters from one asynchronous serial input line. It runs on the system clock and advances only on a sampling tick that an outside baud generator pulses sixteen times per bit. The frame format comes from a 16-bit configuration word. That word sets the number of data bits, the parity mode and the stop-bit length.

Each completed character is packed into one 16-bit result word. The word holds the data bits, a parity-error flag and a framing-error flag, so a consumer always gets the error status together with the character it belongs to. The word stays presented with a valid level until the consumer pulses a take input. If another character completes before the held one is taken, the block raises a one-cycle overflow pulse and the newer character replaces the older one. A line held low for a whole frame (a break) comes out as an all-zero character with the framing error set. The receiver then waits for the line to go high again before it looks for the next start bit.

Top module: `serial_frame_rx`

## Requirements
- R1: A start bit is a low level seen on a tick while idle. It is confirmed on the 8th tick of the bit. After that, one sample is taken every 16 ticks at mid-bit, and data bits arrive least significant bit first into `rx_word[8:0]`.
- R2: `frame_cfg[3:0]` holds the data-bit count minus 3. Values 2 to 6 select 5 to 9 bits, values below 2 select 5 bits and values above 6 select 9 bits. Bits of `rx_word[8:0]` above the configured count read as zero.
- R3: `frame_cfg[9:8]` selects parity: 10 is even, 11 is odd, and 00 or 01 means no parity bit. With parity enabled, the parity bit follows the last data bit, and a mismatch sets `rx_word[14]`.
- R4: `frame_cfg[13:12]` selects the stop length: 00 is half a bit, 01 is one bit, and any value with bit 13 set is two bits. Only the first stop bit is checked, and a low level there sets `rx_word[15]`. A low level during a second stop bit neither flags an error nor starts a new character.
- R5: `rx_word[13:9]` always reads as zero.
- R6: If the line is high again at the confirmation tick of a start bit, the receiver drops the attempt and produces no character.
- R7: A line held low through a whole frame yields data zero with `rx_word[15]` set, and exactly one character results until the line returns high.
- R8: `rx_valid` stays high from a completed character until `rx_take` is pulsed. A character that completes while `rx_valid` is high and `rx_take` is low produces a one-cycle `rx_ovf` pulse and replaces the held word.
- R9: The frame format is captured when the start bit is confirmed. Changes to `frame_cfg` during a frame do not affect that frame.
- R10: After reset, `rx_valid`, `rx_ovf` and `rx_word` are zero.
- R11: With a half stop bit, the stop level is sampled 4 ticks into the stop bit, so a following start bit may begin 8 ticks after the stop bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| frame_cfg | input | 16 | Frame format: data count [3:0], parity [9:8], stop length [13:12] |
| rx_take | input | 1 | Consumer pulse that removes the held character |
| rx_word | output | 16 | Held character: data [8:0], parity error [14], framing error [15] |
| rx_valid | output | 1 | A character is held and not yet taken |
| rx_ovf | output | 1 | One-cycle pulse when a held character was overwritten |

## Verification
The bench covers the following corner cases:
- A short low glitch. A design that did not re-check the start bit at mid-bit would deliver a spurious character.
- A break. A design without the wait-for-high step would emit a stream of zero characters.
- A second stop bit held low. A design that checked it, or that rearmed too early, would flag an error or start a phantom frame.
- A half stop bit followed at once by the next start. A design that sampled late would merge or lose the second character.
- Clamped data counts, both parities with a corrupted parity bit, and a format change in the middle of a frame.
- Overwrite without a take. This must show exactly one overflow pulse and the newer word.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam int WORD_W   = 16;
    localparam int DATA_MAX = 9;
    localparam int IDX_W    = $clog2(DATA_MAX + 1);

    typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} parity_e;
    typedef enum logic [1:0] {STOP_HALF, STOP_ONE, STOP_TWO} stop_e;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_TAIL, ST_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] nbits;
        parity_e          par;
        stop_e            stop;
    } frame_fmt_t;

    // Result word: data in [8:0], parity error [14], framing error [15].
    function automatic logic [WORD_W-1:0] pack_word(
        input logic [DATA_MAX-1:0] d,
        input logic                perr,
        input logic                ferr
    );
        return {ferr, perr, 5'b0, d};
    endfunction

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/frx_cfg_decode.sv
module frx_cfg_decode
    import frx_pkg::*;
(
    input  logic [15:0] cfg_word,
    output frame_fmt_t  fmt
);
    logic [3:0] cnt_field;

    always_comb begin
        cnt_field = cfg_word[3:0];
        if (cnt_field < 4'd2)      fmt.nbits = IDX_W'(5);
        else if (cnt_field > 4'd6) fmt.nbits = IDX_W'(DATA_MAX);
        else                       fmt.nbits = IDX_W'(cnt_field + 4'd3);

        case (cfg_word[9:8])
            2'b10:   fmt.par = PAR_EVEN;
            2'b11:   fmt.par = PAR_ODD;
            default: fmt.par = PAR_NONE;
        endcase

        if (cfg_word[13])      fmt.stop = STOP_TWO;
        else if (cfg_word[12]) fmt.stop = STOP_ONE;
        else                   fmt.stop = STOP_HALF;
    end
endmodule

// File: rtl/frx_engine.sv
module frx_engine
    import frx_pkg::*;
#(
    parameter int OVS = 16   // ticks per bit; multiple of 4, at least 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_bit,
    input  frame_fmt_t        fmt_in,
    output logic              push,
    output logic [WORD_W-1:0] word_out
);
    localparam int HALF     = OVS / 2;
    localparam int QUART    = OVS / 4;
    localparam int TAIL_LEN = OVS + HALF - 2;
    localparam int CW       = $clog2(TAIL_LEN + 1);

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [IDX_W-1:0]    idx;
    logic [DATA_MAX-1:0] data;
    logic                pbit;
    frame_fmt_t          fmt_q;
    logic [CW-1:0]       stop_last;
    logic                par_bad;

    always_comb begin
        stop_last = (fmt_q.stop == STOP_HALF) ? CW'(OVS - QUART - 1) : CW'(OVS - 1);
        par_bad   = (fmt_q.par != PAR_NONE) &&
                    ((^data ^ pbit) != (fmt_q.par == PAR_ODD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            data     <= '0;
            pbit     <= 1'b0;
            fmt_q    <= '{nbits: IDX_W'(8), par: PAR_NONE, stop: STOP_ONE};
            push     <= 1'b0;
            word_out <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: if (!rx_bit) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                    end
                    ST_START: if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        if (rx_bit) state <= ST_IDLE;
                        else begin
                            state <= ST_DATA;
                            idx   <= '0;
                            data  <= '0;
                            pbit  <= 1'b0;
                            fmt_q <= fmt_in;
                        end
                    end else cnt <= cnt + 1'b1;
                    ST_DATA: if (cnt == CW'(OVS - 1)) begin
                        cnt       <= '0;
                        data[idx] <= rx_bit;
                        if (idx == fmt_q.nbits - 1'b1)
                            state <= (fmt_q.par != PAR_NONE) ? ST_PARITY : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                    ST_PARITY: if (cnt == CW'(OVS - 1)) begin
                        cnt   <= '0;
                        pbit  <= rx_bit;
                        state <= ST_STOP;
                    end else cnt <= cnt + 1'b1;
                    ST_STOP: if (cnt == stop_last) begin
                        cnt      <= '0;
                        push     <= 1'b1;
                        word_out <= pack_word(data, par_bad, !rx_bit);
                        if (!rx_bit)                    state <= ST_BRKWAIT;
                        else if (fmt_q.stop == STOP_TWO) state <= ST_TAIL;
                        else                            state <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                    ST_TAIL: if (cnt == CW'(TAIL_LEN - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                    ST_BRKWAIT: if (rx_bit) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_FALSE_START_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && cnt == CW'(HALF - 1) && rx_bit) |=> state == ST_IDLE); // R6
    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        push |-> ((word_out[DATA_MAX-1:0] >> fmt_q.nbits) == '0)); // R2
    AST_BREAK_WAITS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BRKWAIT && !rx_bit) |=> state == ST_BRKWAIT); // R7
    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (rst)
        push |=> !push); // R1
endmodule

// File: rtl/frx_holder.sv
module frx_holder
    import frx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] word_in,
    input  logic              take,
    output logic [WORD_W-1:0] word_q,
    output logic              valid,
    output logic              ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            valid  <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            ovf <= push && valid && !take;
            if (push) begin
                word_q <= word_in;
                valid  <= 1'b1;
            end else if (take) begin
                valid <= 1'b0;
            end
        end
    end

    AST_NO_OVF_WITHOUT_HELD: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(valid)); // R8
    AST_HELD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (valid && !take) |=> valid); // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        valid |-> word_q[13:9] == 5'b0); // R5
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import frx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_tick,
    input  logic        rxd,
    input  logic [15:0] frame_cfg,
    input  logic        rx_take,
    output logic [15:0] rx_word,
    output logic        rx_valid,
    output logic        rx_ovf
);
    logic              rx_clean;
    frame_fmt_t        fmt;
    logic              push;
    logic [WORD_W-1:0] word;

    frx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_clean)
    );

    frx_cfg_decode u_dec (
        .cfg_word(frame_cfg), .fmt(fmt)
    );

    frx_engine #(.OVS(OVS)) u_eng (
        .clk(clk), .rst(rst), .tick(sample_tick), .rx_bit(rx_clean),
        .fmt_in(fmt), .push(push), .word_out(word)
    );

    frx_holder u_hold (
        .clk(clk), .rst(rst), .push(push), .word_in(word), .take(rx_take),
        .word_q(rx_word), .valid(rx_valid), .ovf(rx_ovf)
    );
endmodule

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
    localparam int TDIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] cfg;
    logic        rx_take = 1'b0;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic        rx_ovf;

    int checks = 0;
    int errors = 0;
    int ovf_cnt = 0;
    int cap_n = 0;
    int tdc = 0;
    logic [15:0] cap [0:63];
    logic auto_take = 1'b1;

    serial_frame_rx uut (
        .clk(clk), .rst(rst), .sample_tick(tick), .rxd(rxd), .frame_cfg(cfg),
        .rx_take(rx_take), .rx_word(rx_word), .rx_valid(rx_valid), .rx_ovf(rx_ovf)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdc  <= (tdc == TDIV - 1) ? 0 : tdc + 1;
        tick <= (tdc == TDIV - 1);
        rx_take <= 1'b0;
        if (auto_take && rx_valid && !rx_take) begin
            cap[cap_n] <= rx_word;
            cap_n      <= cap_n + 1;
            rx_take    <= 1'b1;
        end
    end

    always @(posedge clk) if (!rst && rx_ovf) ovf_cnt <= ovf_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcfg(int nb, int par, int stp);
        return 16'(((stp & 3) << 12) | ((par & 3) << 8) | ((nb - 3) & 15));
    endfunction

    task automatic send_bit(input logic b, input int ticks);
        rxd = b;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    // par: 0 none, 2 even, 3 odd
    task automatic send_frame(input logic [8:0] d, input int nb, input int par,
                              input logic flip_par, input logic stop1, input int s1_ticks,
                              input logic two, input logic stop2, input int idle_ticks);
        logic pb;
        pb = 1'b0;
        for (int i = 0; i < nb; i++) pb ^= d[i];
        pb = pb ^ (par == 3) ^ flip_par;
        send_bit(1'b0, 16);
        for (int i = 0; i < nb; i++) send_bit(d[i], 16);
        if (par >= 2) send_bit(pb, 16);
        send_bit(stop1, s1_ticks);
        if (two) send_bit(stop2, 16);
        if (idle_ticks > 0) send_bit(1'b1, idle_ticks);
    endtask

    task automatic t_reset;
        chk("R10 valid", rx_valid, 0);
        chk("R10 ovf", rx_ovf, 0);
        chk("R10 word", rx_word, 0);
    endtask

    task automatic t_basic;
        int b;
        cfg = mkcfg(8, 0, 1);
        b = cap_n;
        send_frame(9'h0A5, 8, 0, 0, 1, 16, 0, 1, 32);
        send_frame(9'h001, 8, 0, 0, 1, 16, 0, 1, 32);
        send_frame(9'h080, 8, 0, 0, 1, 16, 0, 1, 32);
        chk("R1 count", cap_n - b, 3);
        chk("R1 8N1 A5", cap[b], 16'h00A5);
        chk("R1 lsb first 01", cap[b+1], 16'h0001);
        chk("R5 word 80", cap[b+2], 16'h0080);
        chk("R8 cleared by take", rx_valid, 0);
    endtask

    task automatic t_parity;
        int b;
        b = cap_n;
        cfg = mkcfg(7, 2, 1);
        send_frame(9'h035, 7, 2, 0, 1, 16, 0, 1, 32);
        send_frame(9'h035, 7, 2, 1, 1, 16, 0, 1, 32);
        cfg = mkcfg(8, 3, 1);
        send_frame(9'h001, 8, 3, 0, 1, 16, 0, 1, 32);
        send_frame(9'h0F0, 8, 3, 1, 1, 16, 0, 1, 32);
        cfg = mkcfg(8, 1, 1);
        send_frame(9'h0C3, 8, 0, 0, 1, 16, 0, 1, 32);
        chk("R3 even ok", cap[b], 16'h0035);
        chk("R3 even bad", cap[b+1], 16'h4035);
        chk("R3 odd ok", cap[b+2], 16'h0001);
        chk("R3 odd bad", cap[b+3], 16'h40F0);
        chk("R3 code 01 is none", cap[b+4], 16'h00C3);
    endtask

    task automatic t_widths;
        int b;
        b = cap_n;
        cfg = mkcfg(5, 0, 1);
        send_frame(9'h1FF, 5, 0, 0, 1, 16, 0, 1, 32);
        cfg = 16'h1000;
        send_frame(9'h00A, 5, 0, 0, 1, 16, 0, 1, 32);
        cfg = mkcfg(9, 0, 1);
        send_frame(9'h1C3, 9, 0, 0, 1, 16, 0, 1, 32);
        cfg = 16'h100F;
        send_frame(9'h155, 9, 0, 0, 1, 16, 0, 1, 32);
        chk("R2 5 bits", cap[b], 16'h001F);
        chk("R2 clamp low", cap[b+1], 16'h000A);
        chk("R2 9 bits", cap[b+2], 16'h01C3);
        chk("R2 clamp high", cap[b+3], 16'h0155);
    endtask

    task automatic t_stop_err;
        int b;
        b = cap_n;
        cfg = mkcfg(8, 0, 1);
        send_frame(9'h05A, 8, 0, 0, 0, 16, 0, 1, 32);
        chk("R4 framing err", cap[b], 16'h805A);
        chk("R4 one word", cap_n - b, 1);
    endtask

    task automatic t_break;
        int b;
        b = cap_n;
        cfg = mkcfg(8, 0, 1);
        send_bit(1'b0, 16 * 30);
        send_bit(1'b1, 48);
        chk("R7 one word", cap_n - b, 1);
        chk("R7 break word", cap[b], 16'h8000);
        send_frame(9'h033, 8, 0, 0, 1, 16, 0, 1, 32);
        chk("R7 recovers", cap[b+1], 16'h0033);
    endtask

    task automatic t_false_start;
        int b;
        b = cap_n;
        cfg = mkcfg(8, 0, 1);
        send_bit(1'b0, 4);
        send_bit(1'b1, 16 * 12);
        chk("R6 no word", cap_n - b, 0);
        chk("R6 no valid", rx_valid, 0);
    endtask

    task automatic t_two_stop;
        int b;
        b = cap_n;
        cfg = mkcfg(8, 0, 3);
        send_frame(9'h0E7, 8, 0, 0, 1, 16, 1, 0, 16 * 12);
        chk("R4 second stop ignored", cap[b], 16'h00E7);
        chk("R4 no phantom", cap_n - b, 1);
        send_frame(9'h018, 8, 0, 0, 1, 16, 1, 1, 32);
        chk("R4 next ok", cap[b+1], 16'h0018);
    endtask

    task automatic t_half_stop;
        int b;
        b = cap_n;
        cfg = mkcfg(8, 0, 0);
        send_frame(9'h03C, 8, 0, 0, 1, 8, 0, 1, 0);
        send_frame(9'h0C3, 8, 0, 0, 1, 8, 0, 1, 32);
        chk("R11 two words", cap_n - b, 2);
        chk("R11 first", cap[b], 16'h003C);
        chk("R11 second", cap[b+1], 16'h00C3);
    endtask

    task automatic t_overflow;
        int o;
        auto_take = 1'b0;
        o = ovf_cnt;
        cfg = mkcfg(8, 0, 1);
        send_frame(9'h011, 8, 0, 0, 1, 16, 0, 1, 32);
        chk("R8 held", rx_valid, 1);
        chk("R8 no ovf yet", ovf_cnt - o, 0);
        send_frame(9'h022, 8, 0, 0, 1, 16, 0, 1, 32);
        chk("R8 one ovf", ovf_cnt - o, 1);
        chk("R8 newest kept", rx_word, 16'h0022);
        auto_take = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 taken", cap[cap_n-1], 16'h0022);
        chk("R8 valid cleared", rx_valid, 0);
    endtask

    task automatic t_midcfg;
        int b;
        logic [7:0] d;
        b = cap_n;
        d = 8'hB6;
        cfg = mkcfg(8, 0, 1);
        send_bit(1'b0, 16);
        for (int i = 0; i < 3; i++) send_bit(d[i], 16);
        cfg = mkcfg(5, 3, 3);
        for (int i = 3; i < 8; i++) send_bit(d[i], 16);
        send_bit(1'b1, 48);
        chk("R9 format latched", cap[b], 16'h00B6);
        cfg = mkcfg(8, 0, 1);
    endtask

    initial begin
        cfg = 16'h1005;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        send_bit(1'b1, 32);
        t_basic();
        t_parity();
        t_widths();
        t_stop_err();
        t_break();
        t_false_start();
        t_two_stop();
        t_half_stop();
        t_overflow();
        t_midcfg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule